// File: doc/BRIEF.md
# Up/Down Binary-Decade Counter with Preset

A 4-bit synchronous counter that steps up or down on the rising clock edge. A mode input selects the modulus at runtime: modulo-16 binary or modulo-10 decade. A parallel load path takes a 4-bit value from the data inputs. Loading zero is the normal way to clear the count. An asynchronous active-low reset is also provided for chip-level power-up clearing.

Counting is gated by an active-low carry-in. An active-low carry-out marks the terminal count. Several digits can share one clock and form a synchronous chain: each stage's carry-out feeds the next stage's carry-in, and the first stage's carry-in is held low. Carry-out is combinational, so a stage at its terminal value enables the next stage in the same cycle.

Top module: `ud_cnt`

## Requirements
- R1: When rst_ni is low, the count is 0 at once, without waiting for a clock edge.
- R2: With preset_i and ci_ni both low, the count takes its next value on every rising edge of clk_i. All four bits change together.
- R3: When up_i is 1 the count steps up. When up_i is 0 it steps down.
- R4: When bin_i is 1 the count is modulo 16. Up from 15 gives 0, and down from 0 gives 15.
- R5: When bin_i is 0 the count is modulo 10. Up from 9 gives 0, and down from 0 gives 9.
- R6: In decade mode, a count of 10 to 15 returns to the valid range in one step. It goes to 0 when counting up and to 9 when counting down.
- R7: While preset_i is 1, the next rising edge loads data_i, whatever the values of ci_ni and up_i.
- R8: With preset_i low and ci_ni high, the count holds its value across clock edges.
- R9: co_no is 0 exactly when ci_ni is 0 and the count is terminal. The terminal values are:
  - 15 when counting up in binary mode,
  - 9 or above when counting up in decade mode,
  - 0 when counting down in either mode.
- R10: Two stages chained through co_no to ci_ni on a shared clock count as one number. It is modulo 100 in decade mode and modulo 256 in binary mode, in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low clear |
| up_i | input | 1 | 1 = count up, 0 = count down |
| bin_i | input | 1 | 1 = binary modulo 16, 0 = decade modulo 10 |
| preset_i | input | 1 | Parallel load enable |
| data_i | input | 4 | Value to load |
| ci_ni | input | 1 | Active-low carry-in; high inhibits counting |
| cnt_o | output | 4 | Current count |
| co_no | output | 1 | Active-low carry-out at terminal count |

## Verification
Two things can fall in the same cycle: a parallel load, and a count step that carry-in would otherwise allow. The sweep asserts preset with carry-in low, for every start value in both modes and both directions. It then checks that the loaded value appears rather than the stepped one. Carry-out is checked just before each counting edge against an arithmetic model, so that the enable the next digit sees is judged in the same cycle that it acts.

// File: rtl/ud_cnt_pkg.sv
package ud_cnt_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;

  typedef enum logic {
    MOD_DEC = 1'b0,
    MOD_BIN = 1'b1
  } mod_e;
endpackage

// File: rtl/ud_cnt_step.sv
module ud_cnt_step
  import ud_cnt_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int DEC_LAST = 9
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  dir_e             dir_i,
  input  mod_e             mod_i,
  output logic [CNT_W-1:0] nxt_o
);
  localparam logic [CNT_W-1:0] DEC_TOP = CNT_W'(DEC_LAST);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] inc, dec;
  assign inc = cnt_i + ONE;
  assign dec = cnt_i - ONE;

  always_comb begin
    if (mod_i == MOD_BIN) begin
      nxt_o = (dir_i == DIR_UP) ? inc : dec;
    end else if (dir_i == DIR_UP) begin
      // out-of-range codes fold to 0 in one step
      nxt_o = (cnt_i >= DEC_TOP) ? '0 : inc;
    end else begin
      nxt_o = (cnt_i == '0 || cnt_i > DEC_TOP) ? DEC_TOP : dec;
    end
  end
endmodule

// File: rtl/ud_cnt_term.sv
module ud_cnt_term
  import ud_cnt_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int DEC_LAST = 9
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  dir_e             dir_i,
  input  mod_e             mod_i,
  output logic             term_o
);
  localparam logic [CNT_W-1:0] DEC_TOP = CNT_W'(DEC_LAST);
  localparam logic [CNT_W-1:0] BIN_TOP = '1;

  logic at_top, at_bot;
  assign at_top = (mod_i == MOD_BIN) ? (cnt_i == BIN_TOP) : (cnt_i >= DEC_TOP);
  assign at_bot = (cnt_i == '0);
  assign term_o = (dir_i == DIR_UP) ? at_top : at_bot;
endmodule

// File: rtl/ud_cnt_reg.sv
module ud_cnt_reg #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] data_i,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] nxt_i,
  output logic [CNT_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (load_i)  q_o <= data_i;
    else if (!hold_i) q_o <= nxt_i;
  end

  // R7
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> q_o == $past(data_i));

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !load_i) |=> $stable(q_o));

  // R2
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && !load_i) |=> q_o == $past(nxt_i));
endmodule

// File: rtl/ud_cnt.sv
module ud_cnt
  import ud_cnt_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int DEC_LAST = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_i,
  input  logic             bin_i,
  input  logic             preset_i,
  input  logic [CNT_W-1:0] data_i,
  input  logic             ci_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             co_no
);
  localparam logic [CNT_W-1:0] DEC_TOP = CNT_W'(DEC_LAST);
  localparam logic [CNT_W-1:0] BIN_TOP = '1;

  dir_e             dir;
  mod_e             modsel;
  logic [CNT_W-1:0] nxt;
  logic             term;

  assign dir    = dir_e'(up_i);
  assign modsel = mod_e'(bin_i);

  ud_cnt_step #(.CNT_W(CNT_W), .DEC_LAST(DEC_LAST)) step_i (
    .cnt_i (cnt_o),
    .dir_i (dir),
    .mod_i (modsel),
    .nxt_o (nxt)
  );

  ud_cnt_term #(.CNT_W(CNT_W), .DEC_LAST(DEC_LAST)) term_i (
    .cnt_i  (cnt_o),
    .dir_i  (dir),
    .mod_i  (modsel),
    .term_o (term)
  );

  ud_cnt_reg #(.CNT_W(CNT_W)) reg_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (preset_i),
    .data_i (data_i),
    .hold_i (ci_ni),
    .nxt_i  (nxt),
    .q_o    (cnt_o)
  );

  assign co_no = ~(~ci_ni & term);

  // R9
  co_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !co_no |-> !ci_ni);

  // R4
  bin_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bin_i && up_i && !ci_ni && !preset_i && cnt_o == BIN_TOP) |=> cnt_o == '0);

  // R5
  dec_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bin_i && !up_i && !ci_ni && !preset_i && cnt_o == '0) |=> cnt_o == DEC_TOP);

  // R6
  dec_fold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bin_i && !ci_ni && !preset_i && cnt_o > DEC_TOP)
      |=> cnt_o == ($past(up_i) ? '0 : DEC_TOP));

  // R3
  dec_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_i && !ci_ni && !preset_i && cnt_o < DEC_TOP) |=> cnt_o == $past(cnt_o) + 1'b1);
endmodule

// File: tb/ud_cnt_tb_top.sv
module ud_cnt_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       up = 1'b1, bin = 1'b1, preset = 1'b0, ci_n = 1'b1;
  logic [3:0] data = '0;
  logic       hi_preset = 1'b0;
  logic [3:0] cnt_lo, cnt_hi;
  logic       co_lo, co_hi;
  int         vectors = 0, errors = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  ud_cnt dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .up_i(up), .bin_i(bin), .preset_i(preset),
    .data_i(data), .ci_ni(ci_n), .cnt_o(cnt_lo), .co_no(co_lo)
  );

  ud_cnt hi_i (
    .clk_i(clk), .rst_ni(rst_ni), .up_i(up), .bin_i(bin), .preset_i(hi_preset),
    .data_i(4'd0), .ci_ni(co_lo), .cnt_o(cnt_hi), .co_no(co_hi)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int model_nxt(int v, bit u, bit b);
    if (b) return u ? (v + 1) % 16 : (v + 15) % 16;
    if (u) return (v >= 9) ? 0 : v + 1;
    return (v == 0 || v > 9) ? 9 : v - 1;
  endfunction

  function automatic bit model_term(int v, bit u, bit b);
    if (!u) return v == 0;
    return b ? (v == 15) : (v >= 9);
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int base, modv, e;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", cnt_lo, 0);
    chk("R1", cnt_hi, 0);
    rst_ni = 1'b1;

    // R1 asynchronous clear mid-cycle
    ci_n = 1'b0; up = 1'b1; bin = 1'b1;
    repeat (5) tick();
    chk("R2", cnt_lo, 5);
    #3 rst_ni = 1'b0;
    #1 chk("R1", cnt_lo, 0);
    @(negedge clk);
    rst_ni = 1'b1;

    // sweep: mode x direction x start value
    for (int b = 0; b < 2; b++) begin
      for (int u = 0; u < 2; u++) begin
        for (int v = 0; v < 16; v++) begin
          bin = b[0]; up = u[0];
          // R7 preset wins over an enabled count in the same cycle
          ci_n = 1'b0; preset = 1'b1; data = v[3:0];
          tick();
          preset = 1'b0;
          chk("R7", cnt_lo, v);
          // R9 carry-out with carry-in low
          #1 chk("R9", co_lo, model_term(v, u[0], b[0]) ? 0 : 1);
          tick();
          // R3 R4 R5 R6 one step
          chk(b ? "R4" : (v > 9 ? "R6" : (u ? "R3" : "R5")), cnt_lo,
              model_nxt(v, u[0], b[0]));
          // R8 inhibit holds, carry-out stays high
          e = model_nxt(v, u[0], b[0]);
          ci_n = 1'b1;
          #1 chk("R9", co_lo, 1);
          tick();
          tick();
          chk("R8", cnt_lo, e);
        end
      end
    end

    // R10 two-stage cascade
    for (int b = 0; b < 2; b++) begin
      for (int u = 1; u >= 0; u--) begin
        bin = b[0]; up = u[0];
        base = b ? 16 : 10;
        modv = base * base;
        ci_n = 1'b0;
        preset = 1'b1; hi_preset = 1'b1; data = 4'd0;
        tick();
        preset = 1'b0; hi_preset = 1'b0;
        e = 0;
        chk("R10", cnt_hi * base + cnt_lo, e);
        for (int n = 0; n < modv + 3; n++) begin
          tick();
          e = u ? (e + 1) % modv : (e + modv - 1) % modv;
          chk("R10", cnt_hi * base + cnt_lo, e);
        end
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule